// File: doc/BRIEF.md
# Dual Countdown Timer with Identification Window

This block places two programmable down-counters behind one 4 KB register window. Each counter has its own register set, its own clock-enable input and its own interrupt line. It loads from a programmable value, counts on each qualified tick of that clock enable, and raises a sticky flag when it rolls past zero. The address decoder sends accesses to one of the two counters by offset. A fixed block of eight identification words sits at the top of the window. All other offsets read as zero, and writes to them have no effect.

A counter runs in one of three ways. It can be free-running and reload to the all-ones value of its width, it can be periodic and reload to the programmed value, or it can be one-shot and stop at zero. A prescaler divides its tick by 1, 16 or 256, and the counter width is 16 or 32 bits. Reads have no side effects, so read data is a combinational function of the address. Writes take effect at the clock edge where the write strobe is high. The two interrupt flags are each gated by their own enable and then merged onto one shared line for a system interrupt controller.

Top module: `dual_timer_id`

## Requirements
- R1: Byte offsets 0x00–0x1F reach counter 0 and 0x20–0x3F reach counter 1. Inside each counter the register is chosen by word index (offset bits 4:2), so counter 1 sees offset minus 0x20.
- R2: Offsets 0xFE0, 0xFE4, … 0xFFC read the bytes 0x04, 0x18, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, with bits 31:8 zero. Writes there change nothing.
- R3: Reads of any offset outside the two counter regions and the identification words, including 0xF00 and 0xF04, return zero. Writes outside the two counter regions change no state.
- R4: Counter word indices are as follows. Index 0 is the load value, and writing it also reloads the count. Index 1 is the current count and is read-only. Index 2 is control, which resets to 0x20. Writing index 3 clears the raw flag. Index 4 reads the raw flag. Index 5 reads the flag gated by the interrupt enable. Index 6 writes the load value without touching the count. Index 7 reads zero.
- R5: Control bits are: bit 0 one-shot, bit 1 32-bit width (0 means 16-bit), bits 3:2 prescale, bit 5 interrupt enable, bit 6 periodic, bit 7 run.
- R6: On each effective tick the count decrements within its width. A tick taken at zero sets the raw flag and reloads. Periodic and one-shot modes reload the load value. Free-running mode (bits 0 and 6 both clear) reloads 0xFFFF or 0xFFFFFFFF.
- R7: In one-shot mode a tick taken at zero sets the raw flag, clears the run bit and leaves the count at zero.
- R8: Prescale code 01 makes one effective tick per 16 enabled ticks. Code 10 makes one per 256. Codes 00 and 11 make one per tick.
- R9: Each counter's interrupt output is its raw flag ANDed with its interrupt enable. The combined output is the OR of the two. Both are low after reset.
- R10: A counter changes its count only on cycles where its own tick input is high, so the other counter's tick has no effect on it.
- R11: A control write with the run bit set reloads the count from the reload value of the new mode and restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tmr_tick | input | 2 | Per-counter clock enable, bit i drives counter i |
| tmr_irq | output | 2 | Per-counter masked interrupt |
| irq_any | output | 1 | OR of both masked interrupts |

## Verification
The bench uses the default parameters: a 12-bit offset, 32-bit data and an 8-bit prescaler. These make the full identification window and the unmapped holes between 0x40 and 0xFDC addressable. They also let a divide-by-256 run finish in a few hundred cycles. The small load values used (1 to 10) put the zero rollover, the one-shot stop and the background reload within a few ticks. The 16-bit free-running mode shows the width mask on reload.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int DW     = 32;
  localparam int AW     = 12;
  localparam int PRE_W  = 8;
  localparam int N_TMR  = 2;
  localparam int CTRL_W = 8;

  // control bit positions (software decodes these)
  localparam int C_ONESHOT = 0;
  localparam int C_WIDE    = 1;
  localparam int C_PRE_LO  = 2;
  localparam int C_IE      = 5;
  localparam int C_PERIOD  = 6;
  localparam int C_RUN     = 7;

  localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;

  // word indices inside one counter
  localparam logic [2:0] W_LOAD  = 3'd0;
  localparam logic [2:0] W_COUNT = 3'd1;
  localparam logic [2:0] W_CTRL  = 3'd2;
  localparam logic [2:0] W_CLR   = 3'd3;
  localparam logic [2:0] W_RAW   = 3'd4;
  localparam logic [2:0] W_MSK   = 3'd5;
  localparam logic [2:0] W_BGLD  = 3'd6;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0: id_byte = 8'h04;
      3'd1: id_byte = 8'h18;
      3'd2: id_byte = 8'h14;
      3'd3: id_byte = 8'h00;
      3'd4: id_byte = 8'h0D;
      3'd5: id_byte = 8'hF0;
      3'd6: id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic logic [DW-1:0] width_mask(input logic wide);
    width_mask = wide ? {DW{1'b1}} : {{(DW-16){1'b0}}, 16'hFFFF};
  endfunction

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
    case (code)
      2'b01:   pre_limit = PRE_W'(8'h0F);
      2'b10:   pre_limit = PRE_W'(8'hFF);
      default: pre_limit = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] reload_value(input logic [CTRL_W-1:0] c,
                                                 input logic [DW-1:0] lim);
    logic [DW-1:0] m;
    m = width_mask(c[C_WIDE]);
    if (!c[C_ONESHOT] && !c[C_PERIOD]) reload_value = m;
    else                               reload_value = lim & m;
  endfunction
endpackage

// File: rtl/dtim_core.sv
module dtim_core
  import dtim_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr,
  input  logic [2:0]    widx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          step,
  output logic          wrap,
  output logic          ris_o,
  output logic [DW-1:0] count_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     limit, count;
  logic [PRE_W-1:0]  pre;
  logic              ris;

  logic [DW-1:0]    msk;
  logic [PRE_W-1:0] pmax;
  logic             cfg_wr, wr_ctrl, wr_load, wr_bg, wr_clr;
  logic             advance, at_zero;

  always_comb begin
    msk     = width_mask(ctrl[C_WIDE]);
    pmax    = pre_limit(ctrl[C_PRE_LO +: 2]);
    wr_ctrl = wr && (widx == W_CTRL);
    wr_load = wr && (widx == W_LOAD);
    wr_bg   = wr && (widx == W_BGLD);
    wr_clr  = wr && (widx == W_CLR);
    cfg_wr  = wr_ctrl || wr_load || wr_bg;
    advance = ctrl[C_RUN] && tick && !cfg_wr;
    step    = advance && (pre == pmax);
    at_zero = ((count & msk) == '0);
    wrap    = step && at_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= CTRL_RESET;
      limit <= '0;
      count <= '0;
      pre   <= '0;
    end else if (wr_ctrl) begin
      ctrl <= wdata[CTRL_W-1:0];
      pre  <= '0;
      if (wdata[C_RUN]) count <= reload_value(wdata[CTRL_W-1:0], limit);
    end else if (wr_load) begin
      limit <= wdata;
      count <= reload_value(ctrl, wdata);
    end else if (wr_bg) begin
      limit <= wdata;
    end else if (advance) begin
      if (step) begin
        pre <= '0;
        if (!at_zero)             count <= (count - 1'b1) & msk;
        else if (ctrl[C_ONESHOT]) ctrl[C_RUN] <= 1'b0;
        else                      count <= reload_value(ctrl, limit);
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ris <= 1'b0;
    else if (wrap)   ris <= 1'b1;
    else if (wr_clr) ris <= 1'b0;
  end

  always_comb begin
    case (widx)
      W_LOAD, W_BGLD: rdata = limit;
      W_COUNT:        rdata = count;
      W_CTRL:         rdata = {{(DW-CTRL_W){1'b0}}, ctrl};
      W_RAW:          rdata = {{(DW-1){1'b0}}, ris};
      W_MSK:          rdata = {{(DW-1){1'b0}}, ris & ctrl[C_IE]};
      default:        rdata = '0;
    endcase
  end

  assign irq     = ris && ctrl[C_IE];
  assign ris_o   = ris;
  assign count_o = count;
endmodule

// File: rtl/dtim_decode.sv
module dtim_decode
  import dtim_pkg::*;
(
  input  logic [AW-1:0]           addr,
  input  logic                    wr,
  input  logic [N_TMR-1:0][DW-1:0] t_rdata,
  output logic [N_TMR-1:0]        t_wr,
  output logic [2:0]              widx,
  output logic [DW-1:0]           rdata
);
  localparam int SEL_BIT = 5;
  localparam int HI_LSB  = 6;

  logic in_tmr, id_hit, tsel;

  always_comb begin
    in_tmr = (addr[AW-1:HI_LSB] == '0);
    id_hit = (addr[AW-1:SEL_BIT] == '1);
    tsel   = addr[SEL_BIT];
    widx   = addr[4:2];
    for (int i = 0; i < N_TMR; i++)
      t_wr[i] = wr && in_tmr && (tsel == 1'(i));
    if (in_tmr)      rdata = t_rdata[tsel];
    else if (id_hit) rdata = {{(DW-8){1'b0}}, id_byte(widx)};
    else             rdata = '0;
  end
endmodule

// File: rtl/dual_timer_id.sv
module dual_timer_id
  import dtim_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  input  logic [N_TMR-1:0] tmr_tick,
  output logic [N_TMR-1:0] tmr_irq,
  output logic             irq_any
);
  logic [N_TMR-1:0][DW-1:0] t_rdata;
  logic [N_TMR-1:0][DW-1:0] t_count;
  logic [N_TMR-1:0]         t_wr, t_step, t_wrap, t_ris;
  logic [2:0]               widx;

  dtim_decode u_dec (
    .addr    (bus_addr),
    .wr      (bus_wr),
    .t_rdata (t_rdata),
    .t_wr    (t_wr),
    .widx    (widx),
    .rdata   (bus_rdata)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    dtim_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tmr_tick[g]),
      .wr      (t_wr[g]),
      .widx    (widx),
      .wdata   (bus_wdata),
      .rdata   (t_rdata[g]),
      .irq     (tmr_irq[g]),
      .step    (t_step[g]),
      .wrap    (t_wrap[g]),
      .ris_o   (t_ris[g]),
      .count_o (t_count[g])
    );
  end

  assign irq_any = |tmr_irq;
endmodule

// File: rtl/dtim_chk.sv
module dtim_chk
  import dtim_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [AW-1:0]            bus_addr,
  input logic [DW-1:0]            bus_rdata,
  input logic [N_TMR-1:0]         tmr_tick,
  input logic [N_TMR-1:0]         tmr_irq,
  input logic                     irq_any,
  input logic [N_TMR-1:0]         t_step,
  input logic [N_TMR-1:0]         t_wrap,
  input logic [N_TMR-1:0]         t_ris,
  input logic [N_TMR-1:0][DW-1:0] t_count
);
  AST_ID_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[AW-1:5] == '1) |-> (bus_rdata[DW-1:8] == '0)); // R2

  AST_MERGE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> (t_ris != '0)); // R9

  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      t_wrap[g] |=> t_ris[g]); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_irq[g] |-> t_ris[g]); // R9

    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !tmr_tick[g] |-> !t_step[g]); // R10

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmr_tick[g] && !bus_wr) |=> $stable(t_count[g])); // R10

    AST_OUTSIDE_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr[AW-1:6] != '0 && !tmr_tick[g])
        |=> ($stable(t_count[g]) && $stable(t_ris[g]))); // R3
  end
endmodule

bind dual_timer_id dtim_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tmr_tick  (tmr_tick),
  .tmr_irq   (tmr_irq),
  .irq_any   (irq_any),
  .t_step    (t_step),
  .t_wrap    (t_wrap),
  .t_ris     (t_ris),
  .t_count   (t_count)
);

// File: tb/dual_timer_id_tb_top.sv
module dual_timer_id_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  tmr_tick = '0;
  logic [1:0]  tmr_irq;
  logic        irq_any;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_timer_id dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick),
    .tmr_irq(tmr_irq), .irq_any(irq_any)
  );

  // {offset, expected read value} after reset
  localparam logic [43:0] VEC [16] = '{
    {12'hFE0, 32'h04}, {12'hFE4, 32'h18}, {12'hFE8, 32'h14}, {12'hFEC, 32'h00},
    {12'hFF0, 32'h0D}, {12'hFF4, 32'hF0}, {12'hFF8, 32'h05}, {12'hFFC, 32'hB1},
    {12'hF00, 32'h00}, {12'hF04, 32'h00}, {12'h040, 32'h00}, {12'h100, 32'h00},
    {12'h008, 32'h20}, {12'h028, 32'h20}, {12'h000, 32'h00}, {12'h014, 32'h00}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic tick(input int idx, input int n);
    @(negedge clk);
    tmr_tick[idx] = 1'b1;
    repeat (n) @(negedge clk);
    tmr_tick[idx] = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R9 reset irq", {30'd0, tmr_irq}, 32'd0);
    check("R9 reset irq_any", {31'd0, irq_any}, 32'd0);

    for (int i = 0; i < 16; i++) begin
      string tag;
      tag = (i < 8) ? "R2 id" : (i < 12) ? "R3 unmapped" : (i < 14) ? "R4 R1 ctrl reset" : "R4 reset";
      rd_chk(tag, VEC[i][43:32], VEC[i][31:0]);
    end

    // R6 periodic rollover on counter 0
    wr(12'h000, 32'd3);
    wr(12'h008, 32'hE2);
    rd_chk("R4 load", 12'h004, 32'd3);
    tick(0, 3);
    rd_chk("R6 count down", 12'h004, 32'd0);
    check("R6 no irq yet", {30'd0, tmr_irq}, 32'd0);
    tick(0, 1);
    #1;
    check("R9 irq0", {30'd0, tmr_irq}, 32'd1);
    check("R9 irq_any", {31'd0, irq_any}, 32'd1);
    rd_chk("R6 periodic reload", 12'h004, 32'd3);
    rd_chk("R4 raw", 12'h010, 32'd1);
    rd_chk("R4 masked", 12'h014, 32'd1);
    rd_chk("R1 t1 raw", 12'h030, 32'd0);

    wr(12'h00C, 32'd0);
    rd_chk("R4 clear", 12'h010, 32'd0);
    check("R9 cleared any", {31'd0, irq_any}, 32'd0);

    // R10 counter 1 alone
    wr(12'h020, 32'd10);
    wr(12'h028, 32'hE2);
    tick(1, 5);
    rd_chk("R10 t1 count", 12'h024, 32'd5);
    rd_chk("R10 t0 held", 12'h004, 32'd3);

    // R3 / R4 / R2 ignored writes
    wr(12'h004, 32'h55);
    rd_chk("R4 count read-only", 12'h004, 32'd3);
    wr(12'hFE0, 32'h77);
    rd_chk("R2 id read-only", 12'hFE0, 32'h04);
    wr(12'h040, 32'hFFFF);
    wr(12'h800, 32'hFFFF);
    rd_chk("R3 t0 load kept", 12'h000, 32'd3);
    rd_chk("R3 t1 load kept", 12'h020, 32'd10);
    rd_chk("R3 t1 ctrl kept", 12'h028, 32'hE2);
    rd_chk("R3 t1 count kept", 12'h024, 32'd5);

    // R11 control write reloads, R9 mask on counter 1
    wr(12'h028, 32'hC2);
    rd_chk("R11 ctrl reload", 12'h024, 32'd10);
    tick(1, 11);
    rd_chk("R9 t1 raw", 12'h030, 32'd1);
    rd_chk("R9 t1 masked", 12'h034, 32'd0);
    #1;
    check("R9 masked irq1", {30'd0, tmr_irq}, 32'd0);
    check("R9 masked any", {31'd0, irq_any}, 32'd0);
    wr(12'h02C, 32'd0);

    // R7 one-shot on counter 0
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hA3);
    tick(0, 2);
    rd_chk("R7 at zero", 12'h004, 32'd0);
    check("R7 not fired", {30'd0, tmr_irq}, 32'd0);
    tick(0, 1);
    #1;
    check("R7 fired", {30'd0, tmr_irq}, 32'd1);
    rd_chk("R7 run cleared", 12'h008, 32'h23);
    tick(0, 3);
    rd_chk("R7 holds zero", 12'h004, 32'd0);
    wr(12'h00C, 32'd0);

    // R6 R5 16-bit free-running
    wr(12'h008, 32'hA0);
    rd_chk("R6 free 16 reload", 12'h004, 32'h0000FFFF);
    tick(0, 1);
    rd_chk("R5 16-bit dec", 12'h004, 32'h0000FFFE);

    // R8 prescale
    wr(12'h000, 32'd1);
    wr(12'h008, 32'hE6);
    tick(0, 15);
    rd_chk("R8 div16 hold", 12'h004, 32'd1);
    tick(0, 1);
    rd_chk("R8 div16 step", 12'h004, 32'd0);
    wr(12'h008, 32'hEA);
    tick(0, 255);
    rd_chk("R8 div256 hold", 12'h004, 32'd1);
    tick(0, 1);
    rd_chk("R8 div256 step", 12'h004, 32'd0);

    // R4 background load
    wr(12'h008, 32'hE2);
    wr(12'h018, 32'd9);
    rd_chk("R4 bg load value", 12'h000, 32'd9);
    rd_chk("R4 bg count kept", 12'h004, 32'd1);
    tick(0, 2);
    rd_chk("R4 bg reload", 12'h004, 32'd9);
    #1;
    check("R6 bg wrap irq", {30'd0, tmr_irq}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule